// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers one-cycle event strobes from five interrupt sources (two timers, a time-of-day alarm, a serial shifter and an edge-detected flag pin) into a sticky status register. A mask decides which of them may raise the shared active-low interrupt request line. Software reads the status to learn which sources fired and to acknowledge them. It writes the same address to set or clear mask bits.

All state lives in one system clock domain. A single-cycle enable marks the falling edge of the bus phase clock. Outside read cycles, the request line moves only at such an edge. Timing follows a fixed set of skews. The summary bit of the read value trails the latched flags by one cycle. A read drops the request line at once and empties the flags on the following cycle. A write empties the flags two cycles after it is issued.

Top module: `icr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags and mask bits are 0, the read value is 0x00 and irq_n is 1.
- R2: A strobe on src_evt bit i sets flag bit i in the next cycle, whether or not mask bit i is set. Flags stay set until cleared. Read value bits 0..4 are the flags in the order timer A, timer B, alarm, serial, flag pin. Bits 5 and 6 always read 0.
- R3: Read value bit 7 in a cycle equals the OR over all i of (flag i AND mask i) taken in the previous cycle. This holds for both rising and falling transitions.
- R4: A cycle with rd_stb high returns the current flags. In the next cycle the flags hold only the strobes that arrived during the read cycle.
- R5: A cycle with wr_stb high and no read leaves the flags in place for one more cycle. Two cycles after the write, the flags hold only the strobes that arrived in the cycle just before.
- R6: On a write, wr_data bits 0..4 select mask bits. If wr_data bit 7 is 1, the selected bits are set. If it is 0, they are cleared. Unselected mask bits keep their value. The new mask is in effect from the next cycle.
- R7: irq_n is 1 in every cycle in which rd_stb is high.
- R8: An internal request state updates only at clock edges where phi2_fall or rd_stb is high. At such an edge it becomes the OR over i of (next flag i AND next mask i). irq_n is the inverse of this state, except during read cycles.
- R9: If a masked-in source strobes on every cycle, a one-cycle read raises irq_n for exactly that cycle. irq_n is 0 again in the next cycle, and bit 7 stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phi2_fall | input | 1 | One-cycle enable marking a bus-phase falling edge |
| src_evt | input | 5 | Per-source event strobes |
| rd_stb | input | 1 | Read strobe to the status address |
| wr_stb | input | 1 | Write strobe to the status/mask address |
| wr_data | input | 8 | Write data; bit 7 selects set or clear |
| rd_data | output | 8 | Status read value |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is the read and write clear racing against new strobes. A strobe that lands in the clearing cycle must survive, and the request line must come back one cycle after a read while a source keeps firing. The bench keeps one source strobing on every cycle while it issues reads. It also places writes so that their delayed clear lands on a fresh strobe. A sweep over all 32 mask values, every single source and a pseudo-random mix of strobes, reads, writes and sparse phase edges follows. Each cycle is compared against an arithmetic model of the requirements.

// File: rtl/icr_pkg.sv
// Shared widths and bit positions for the interrupt status/mask controller.
package icr_pkg;
    localparam int ICR_SRC_N  = 5;   // timer A, timer B, alarm, serial, flag pin
    localparam int ICR_DATA_W = 8;   // bus data width, summary in the top bit
    localparam int ICR_WR_LAT = 2;   // cycles from a write to visible clear

    // source index map, bit positions of the status value
    typedef enum int {
        SRC_TMR_A  = 0,
        SRC_TMR_B  = 1,
        SRC_ALARM  = 2,
        SRC_SERIAL = 3,
        SRC_PIN    = 4
    } icr_src_e;
endpackage

// File: rtl/icr_clear_ctl.sv
// Produces the flag clear pulse: immediately registered from a read, and
// delayed WR_LAT-1 stages from a write. Assumes one-cycle bus strobes.
module icr_clear_ctl #(
    parameter int WR_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic wr_stb,
    output logic clr
);
    logic wr_clr;

    generate
        if (WR_LAT <= 1) begin : g_direct
            assign wr_clr = wr_stb;
        end else begin : g_pipe
            localparam int STAGES = WR_LAT - 1;
            logic [STAGES-1:0] pipe_q;
            // shift the write strobe down the delay line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= wr_stb;
                    for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
                end
            end
            assign wr_clr = pipe_q[STAGES-1];
        end
    endgenerate

    // clear request applied at the coming edge
    always_comb clr = rd_stb | wr_clr;
endmodule

// File: rtl/icr_flag_bank.sv
// Sticky per-source flags. A clear empties the bank at the edge, but strobes
// present in the same cycle are still captured. Assumes strobes are 1 cycle.
module icr_flag_bank #(
    parameter int SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_evt,
    input  logic             clr,
    input  logic             rd_stb,
    output logic [SRC_N-1:0] flags_q,
    output logic [SRC_N-1:0] flags_next
);
    // next flag value: keep or drop old flags, then add new strobes
    always_comb flags_next = (clr ? '0 : flags_q) | src_evt;

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_next;
    end

    // R2
    flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((flags_q & $past(src_evt)) == $past(src_evt)));
    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (flags_q == $past(src_evt)));
    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/icr_mask_reg.sv
// Mask register with set/clear write semantics: data top bit picks the
// direction, low bits pick the mask bits touched.
module icr_mask_reg #(
    parameter int SRC_N  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SRC_N-1:0]  mask_q,
    output logic [SRC_N-1:0]  mask_next
);
    logic [SRC_N-1:0] sel;
    logic             set_dir;
    logic             unused_mid_bits;

    assign sel             = wr_data[SRC_N-1:0];
    assign set_dir         = wr_data[DATA_W-1];
    assign unused_mid_bits = ^wr_data[DATA_W-2:SRC_N];

    // next mask after an optional set/clear write
    always_comb begin
        mask_next = mask_q;
        if (wr_stb) mask_next = set_dir ? (mask_q | sel) : (mask_q & ~sel);
    end

    // mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next;
    end

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data[DATA_W-1]) |=> ((mask_q & $past(sel)) == $past(sel)));
    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_data[DATA_W-1]) |=> ((mask_q & $past(sel)) == '0));
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(mask_q));
endmodule

// File: rtl/icr_irq_out.sv
// Summary bit and request line. The summary trails pending flags by one
// cycle. The request state samples the next pending value at phase falling
// edges and on reads, and a read masks the pin during its own cycle.
module icr_irq_out #(
    parameter int SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phi2_fall,
    input  logic             rd_stb,
    input  logic [SRC_N-1:0] flags_q,
    input  logic [SRC_N-1:0] mask_q,
    input  logic [SRC_N-1:0] flags_next,
    input  logic [SRC_N-1:0] mask_next,
    output logic             sum_q,
    output logic             irq_n
);
    logic pend_now;
    logic pend_next;
    logic req_q;

    assign pend_now  = |(flags_q & mask_q);
    assign pend_next = |(flags_next & mask_next);

    // summary bit, one cycle behind the pending flags
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= 1'b0;
        else        sum_q <= pend_now;
    end

    // request state, updated at phase falling edges and reads
    always_ff @(posedge clk) begin
        if (!rst_n)                 req_q <= 1'b0;
        else if (phi2_fall || rd_stb) req_q <= pend_next;
    end

    // pin: released for the whole read cycle
    always_comb irq_n = ~(req_q & ~rd_stb);

    // R3
    sum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_q) |-> $past(pend_now));
    // R3
    sum_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sum_q) |-> !$past(pend_now));
    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> irq_n);
    // R8
    pin_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !$past(rd_stb) && !$past(phi2_fall)) |-> $stable(irq_n));
endmodule

// File: rtl/icr_ctrl.sv
// Top of the interrupt status/mask controller: flag bank, mask register,
// clear timing and request output, plus the read value assembly.
module icr_ctrl
    import icr_pkg::*;
#(
    parameter int SRC_N  = ICR_SRC_N,
    parameter int DATA_W = ICR_DATA_W,
    parameter int WR_LAT = ICR_WR_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2_fall,
    input  logic [SRC_N-1:0]  src_evt,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic             clr;
    logic [SRC_N-1:0] flags_q, flags_next;
    logic [SRC_N-1:0] mask_q, mask_next;
    logic             sum_q;

    icr_clear_ctl #(.WR_LAT(WR_LAT)) u_clr (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .clr(clr)
    );

    icr_flag_bank #(.SRC_N(SRC_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr(clr),
        .rd_stb(rd_stb), .flags_q(flags_q), .flags_next(flags_next)
    );

    icr_mask_reg #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .mask_q(mask_q), .mask_next(mask_next)
    );

    icr_irq_out #(.SRC_N(SRC_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .phi2_fall(phi2_fall), .rd_stb(rd_stb),
        .flags_q(flags_q), .mask_q(mask_q), .flags_next(flags_next),
        .mask_next(mask_next), .sum_q(sum_q), .irq_n(irq_n)
    );

    // read value: flags low, zero padding, summary in the top bit
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_rd
            if (b < SRC_N) begin : g_flag
                assign rd_data[b] = flags_q[b];
            end else if (b == DATA_W - 1) begin : g_sum
                assign rd_data[b] = sum_q;
            end else begin : g_pad
                assign rd_data[b] = 1'b0;
            end
        end
    endgenerate

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-2:SRC_N] == '0);
    // R5
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_stb) && !$past(rd_stb) && !rd_stb && !$past(clr))
            |-> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: tb/icr_ctrl_tb.sv
module icr_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       phi2_fall;
    logic [4:0] src_evt;
    logic       rd_stb;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state built from the requirements
    logic [4:0] m_flags, m_mask;
    logic       m_sum, m_req, m_wrd;

    always #(CLK_PERIOD/2) clk = ~clk;

    icr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .phi2_fall(phi2_fall), .src_evt(src_evt),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic compare8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s rd_data actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s irq_n actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, check outputs mid-cycle, advance the model
    task automatic step(input logic [4:0] s, input logic r, input logic w,
                        input logic [7:0] d, input logic f, input string tag);
        logic       clr;
        logic [4:0] fn, mn;
        @(negedge clk);
        src_evt = s; rd_stb = r; wr_stb = w; wr_data = d; phi2_fall = f;
        #2;
        compare8(tag, rd_data, {m_sum, 2'b00, m_flags});
        compare1(tag, irq_n, ~(m_req & ~r));
        clr = r | m_wrd;
        fn  = (clr ? 5'd0 : m_flags) | s;
        mn  = w ? (d[7] ? (m_mask | d[4:0]) : (m_mask & ~d[4:0])) : m_mask;
        m_sum = |(m_flags & m_mask);
        if (f || r) m_req = |(fn & mn);
        m_wrd   = w;
        m_flags = fn;
        m_mask  = mn;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(5'd0, 1'b0, 1'b0, 8'h00, 1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; phi2_fall = 1'b0; src_evt = '0;
        rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
        m_flags = '0; m_mask = '0; m_sum = 1'b0; m_req = 1'b0; m_wrd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle(2, "R1");

        // R2: unmasked strobes latch, bits 5/6 stay 0, no request
        step(5'b10101, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
        idle(3, "R2");
        step(5'd0, 1'b1, 1'b0, 8'h00, 1'b1, "R4");
        idle(2, "R4");

        // R6 / R3 / R8: every mask value against every single source
        for (int m = 0; m < 32; m++) begin
            step(5'd0, 1'b0, 1'b1, 8'h1F, 1'b0, "R6");
            step(5'd0, 1'b0, 1'b1, {3'b100, m[4:0]}, 1'b1, "R6");
            for (int s = 0; s < 5; s++) begin
                step(5'd1 << s, 1'b0, 1'b0, 8'h00, 1'b0, "R8");
                step(5'd0, 1'b0, 1'b0, 8'h00, 1'b0, "R3");
                step(5'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R8");
                idle(1, "R3");
                step(5'd0, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
                idle(2, "R4");
            end
            // selective clear of some mask bits
            step(5'd0, 1'b0, 1'b1, {3'b000, m[0], m[2], 1'b0, m[1], m[3]}, 1'b1, "R6");
            step(5'b11111, 1'b0, 1'b0, 8'h00, 1'b1, "R6");
            idle(2, "R6");
            step(5'd0, 1'b1, 1'b0, 8'h00, 1'b1, "R4");
            idle(1, "R4");
        end

        // R5: write clear two cycles later, with a strobe racing the clear
        step(5'd0, 1'b0, 1'b1, 8'h9F, 1'b1, "R5");
        step(5'b00011, 1'b0, 1'b0, 8'h00, 1'b1, "R5");
        step(5'd0, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
        step(5'b01000, 1'b0, 1'b0, 8'h00, 1'b1, "R5");
        idle(3, "R5");
        step(5'd0, 1'b0, 1'b1, 8'h00, 1'b0, "R5");
        step(5'b00100, 1'b0, 1'b0, 8'h00, 1'b0, "R5");
        idle(3, "R5");

        // R9: timer A strobing every cycle, reads in between
        step(5'd0, 1'b0, 1'b1, 8'h81, 1'b1, "R9");
        for (int i = 0; i < 40; i++)
            step(5'b00001, (i % 7) == 3, 1'b0, 8'h00, 1'b1, "R9");
        step(5'd0, 1'b1, 1'b0, 8'h00, 1'b1, "R9");
        idle(3, "R9");

        // R8 / R4 / R5: pseudo-random mix with sparse phase edges
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[4:0] & {5{lfsr[9]}}, lfsr[12:10] == 3'b000,
                 lfsr[15:13] == 3'b000, {lfsr[16], lfsr[23:17]},
                 lfsr[25:24] == 2'b00, "R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule